// File: doc/BRIEF.md
# Debug Exit and Restart Controller

This block decides when a halted processor core goes back to normal execution. It takes four kinds of input. It watches the state code of an external JTAG TAP controller and the TAP instruction register. It also sees a per-instruction speed flag each time a word is clocked into the debug data chain, and a request to enter debug state. From these it drives three things:

- a debug-acknowledge output,
- a scan-chain mode select (system or debug),
- a clock-source select (system clock qualified by its enable, or the debug clock).

Loading the RESTART opcode does not resume the core straight away. It only marks a restart as pending. The core resumes on the next cycle in which the TAP moves into Run-Test/Idle. Several cores that share one TAP can therefore be armed one by one and then released on the same cycle. If the TAP passes through Test-Logic-Reset first, the pending restart is dropped. The controller also reports whether the most recent chain instruction asked for system speed, which is how the final no-operation of an exit sequence prepares the resynchronisation.

Top module: `dbg_resume_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the outputs read as follows: dbg_ack is 0, clk_sys_sel is 1, chain_sys_mode is 1, restart_pending is 0 and sys_speed_armed is 0.
- R2: When dbg_req is 1 and the core is not halted, the next cycle shows dbg_ack 1, clk_sys_sel 0 and chain_sys_mode 0.
- R3: ir_update with ir_value equal to RESTART_OP (default 4'b0100) while halted sets restart_pending on the next cycle. Any other opcode leaves it clear, and so does any opcode while the core is not halted.
- R4: When restart_pending is 1 and tap_state changes into TAP_RTI (default 4'hC) from a different code, the next cycle shows all of the following together: dbg_ack 0, clk_sys_sel 1, chain_sys_mode 1, restart_pending 0 and sys_speed_armed 0.
- R5: Entering TAP_RTI with no restart pending leaves the core halted.
- R6: tap_state equal to TAP_TLR (default 4'hF) clears a pending restart on the next cycle. A later entry into TAP_RTI then does not resume the core.
- R7: If a RESTART decode and TAP_TLR fall in the same cycle, the cancel wins and restart_pending stays 0.
- R8: While halted, instr_load copies instr_sysspeed into sys_speed_armed (1 = the instruction runs at system speed, 0 = debug speed). Outside debug state instr_load is ignored.
- R9: After a resume, dbg_ack stays 0 until a dbg_req is seen while not halted. A dbg_req that is present in the resume cycle itself is not acted on.
- R10: A resume needs an entry into TAP_RTI. Staying in TAP_RTI while a restart becomes pending does not resume the core until the TAP leaves TAP_RTI and comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_req | input | 1 | Request to enter debug state |
| tap_state | input | TAP_W | Current TAP controller state code |
| ir_update | input | 1 | Strobe: the instruction register has just been loaded |
| ir_value | input | IR_W | Instruction register contents |
| instr_load | input | 1 | Strobe: an instruction has been clocked into the debug chain |
| instr_sysspeed | input | 1 | Speed flag (bit 32) of that instruction |
| dbg_ack | output | 1 | High for the whole time the core is in debug state |
| clk_sys_sel | output | 1 | 1 selects the system clock with its enable, 0 the debug clock |
| chain_sys_mode | output | 1 | 1 = scan chain in system mode, 0 = debug mode |
| restart_pending | output | 1 | RESTART decoded and waiting for Run-Test/Idle |
| sys_speed_armed | output | 1 | Last chain instruction carried the system-speed flag |

## Verification
Two pairs of events can fall in the same cycle, and both are tested.

The first pair is a RESTART decode and a cancel. The bench pulses ir_update with the RESTART opcode while tap_state sits at Test-Logic-Reset. The cancel must win, so restart_pending must still read 0 one cycle later.

The second pair is the resume and a new debug request. The bench holds dbg_req high on the very cycle the TAP enters Run-Test/Idle with a restart pending. It then expects the full system-mode output pattern, not a re-halt, and it expects dbg_ack to stay low once dbg_req is gone.

// File: rtl/dbg_resume_ctrl.sv
`timescale 1ns/1ps
module dbg_resume_ctrl #(
  parameter int TAP_W = 4,
  parameter int IR_W  = 4,
  parameter logic [TAP_W-1:0] TAP_RTI = 4'hC,
  parameter logic [TAP_W-1:0] TAP_TLR = 4'hF,
  parameter logic [IR_W-1:0]  RESTART_OP = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_req,
  input  logic [TAP_W-1:0] tap_state,
  input  logic             ir_update,
  input  logic [IR_W-1:0]  ir_value,
  input  logic             instr_load,
  input  logic             instr_sysspeed,
  output logic             dbg_ack,
  output logic             clk_sys_sel,
  output logic             chain_sys_mode,
  output logic             restart_pending,
  output logic             sys_speed_armed
);

  logic             halted;
  logic             pend;
  logic             armed;
  logic [TAP_W-1:0] tap_q;

  wire rti_enter   = (tap_state == TAP_RTI) && (tap_q != TAP_RTI);
  wire in_tlr      = (tap_state == TAP_TLR);
  wire restart_dec = halted && ir_update && (ir_value == RESTART_OP);
  wire resume      = halted && pend && rti_enter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
      pend   <= 1'b0;
      armed  <= 1'b0;
      tap_q  <= TAP_TLR;
    end else begin
      tap_q <= tap_state;
      if (!halted) begin
        halted <= dbg_req;
        pend   <= 1'b0;
        armed  <= 1'b0;
      end else if (resume) begin
        halted <= 1'b0;
        pend   <= 1'b0;
        armed  <= 1'b0;
      end else begin
        if (in_tlr)           pend <= 1'b0;
        else if (restart_dec) pend <= 1'b1;
        if (instr_load)       armed <= instr_sysspeed;
      end
    end
  end

  assign dbg_ack         = halted;
  assign clk_sys_sel     = ~halted;
  assign chain_sys_mode  = ~halted;
  assign restart_pending = pend;
  assign sys_speed_armed = armed;

endmodule

module dbg_resume_ctrl_chk #(
  parameter int TAP_W = 4,
  parameter logic [TAP_W-1:0] TAP_RTI = 4'hC,
  parameter logic [TAP_W-1:0] TAP_TLR = 4'hF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_req,
  input logic [TAP_W-1:0] tap_state,
  input logic [TAP_W-1:0] tap_q,
  input logic             dbg_ack,
  input logic             clk_sys_sel,
  input logic             chain_sys_mode,
  input logic             restart_pending,
  input logic             sys_speed_armed
);

  // R2
  enter_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_ack && dbg_req) |=> (dbg_ack && !clk_sys_sel && !chain_sys_mode));

  // R4
  resume_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ack && restart_pending && tap_state == TAP_RTI && tap_q != TAP_RTI)
    |=> (!dbg_ack && clk_sys_sel && chain_sys_mode && !restart_pending && !sys_speed_armed));

  // R5
  hold_without_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ack && !restart_pending) |=> dbg_ack);

  // R6
  tlr_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_state == TAP_TLR) |=> !restart_pending);

  // R9
  no_reack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_ack && !dbg_req) |=> !dbg_ack);

  // R3
  pending_only_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_ack |=> !restart_pending);

endmodule

bind dbg_resume_ctrl dbg_resume_ctrl_chk #(
  .TAP_W(TAP_W), .TAP_RTI(TAP_RTI), .TAP_TLR(TAP_TLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .tap_state(tap_state),
  .tap_q(tap_q), .dbg_ack(dbg_ack), .clk_sys_sel(clk_sys_sel),
  .chain_sys_mode(chain_sys_mode), .restart_pending(restart_pending),
  .sys_speed_armed(sys_speed_armed)
);

// File: tb/tb_dbg_resume_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_resume_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dbg_req = 1'b0;
  logic [3:0] tap_state = 4'h2;
  logic       ir_update = 1'b0;
  logic [3:0] ir_value = 4'h0;
  logic       instr_load = 1'b0;
  logic       instr_sysspeed = 1'b0;
  logic dbg_ack, clk_sys_sel, chain_sys_mode, restart_pending, sys_speed_armed;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { logic [4:0] exp; string tag; } item_t;
  item_t sb[$];

  localparam logic [4:0] RUN  = 5'b01100;
  localparam logic [4:0] HALT = 5'b10000;
  localparam logic [3:0] RTI = 4'hC, TLR = 4'hF, SDR = 4'h2, RST_OP = 4'b0100;

  always #2 clk = ~clk;

  dbg_resume_ctrl dut (
    .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .tap_state(tap_state),
    .ir_update(ir_update), .ir_value(ir_value), .instr_load(instr_load),
    .instr_sysspeed(instr_sysspeed), .dbg_ack(dbg_ack), .clk_sys_sel(clk_sys_sel),
    .chain_sys_mode(chain_sys_mode), .restart_pending(restart_pending),
    .sys_speed_armed(sys_speed_armed)
  );

  wire [4:0] obs = {dbg_ack, clk_sys_sel, chain_sys_mode, restart_pending, sys_speed_armed};

  task automatic compare(input logic [4:0] exp, input string tag);
    checks++;
    if (obs !== exp) begin
      failures++;
      $display("FAIL %s: outputs(ack,clk,chain,pend,armed)=%b expected %b", tag, obs, exp);
    end
  endtask

  task automatic step(input logic req, input logic [3:0] tap, input logic iru,
                      input logic [3:0] ir, input logic ld, input logic fl,
                      input logic [4:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    dbg_req = req; tap_state = tap; ir_update = iru; ir_value = ir;
    instr_load = ld; instr_sysspeed = fl;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      compare(it.exp, it.tag);
    end
  end

  initial begin
    #1;
    repeat (3) @(negedge clk);
    compare(RUN, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare(RUN, "R1 after reset");
    step(0, SDR, 0, 0, 0, 0, RUN, "R9 idle");
    step(0, SDR, 1, RST_OP, 0, 0, RUN, "R3 restart ignored when running");
    step(0, SDR, 0, 0, 1, 1, RUN, "R8 load ignored when running");
    step(1, SDR, 0, 0, 0, 0, HALT, "R2 enter debug");
    step(1, SDR, 0, 0, 0, 0, HALT, "R2 stay halted");
    step(0, SDR, 1, 4'h3, 0, 0, HALT, "R3 other opcode");
    step(0, RTI, 0, 0, 0, 0, HALT, "R5 RTI without pending");
    step(0, SDR, 0, 0, 0, 0, HALT, "R5 leave RTI");
    step(0, SDR, 0, 0, 1, 1, 5'b10001, "R8 flag high");
    step(0, SDR, 0, 0, 1, 0, HALT, "R8 flag low");
    step(0, SDR, 0, 0, 1, 1, 5'b10001, "R8 flag high again");
    step(0, SDR, 1, RST_OP, 0, 0, 5'b10011, "R3 restart decoded");
    step(0, TLR, 0, 0, 0, 0, 5'b10001, "R6 TLR cancels");
    step(0, RTI, 0, 0, 0, 0, 5'b10001, "R6 no resume after cancel");
    step(0, TLR, 1, RST_OP, 0, 0, 5'b10001, "R7 cancel beats decode");
    step(0, SDR, 1, RST_OP, 0, 0, 5'b10011, "R3 restart decoded again");
    step(1, RTI, 0, 0, 0, 0, RUN, "R4 resume with req present");
    step(0, RTI, 0, 0, 0, 0, RUN, "R9 no reacknowledge");
    step(0, SDR, 0, 0, 0, 0, RUN, "R9 still running");
    step(1, RTI, 0, 0, 0, 0, HALT, "R2 reenter debug");
    step(0, RTI, 1, RST_OP, 0, 0, 5'b10010, "R10 pending while in RTI");
    step(0, RTI, 0, 0, 0, 0, 5'b10010, "R10 no resume without entry");
    step(0, 4'h1, 0, 0, 0, 0, 5'b10010, "R10 leave RTI");
    step(0, RTI, 0, 0, 0, 0, RUN, "R4 resume on reentry");
    step(0, SDR, 0, 0, 0, 0, RUN, "R9 idle after resume");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule